// File: doc/BRIEF.md
# Periodic Microinterrupt Down-Timer

This block gives a small microprogrammed controller a steady interrupt for housekeeping work such as scanning keyboards for keystrokes. A fast reference clock passes through two fixed divide stages (by 16, then by 512), which turns 8 MHz into a tick of about 1 kHz. Each tick steps a 5-bit down counter. The controller writes the period, in ticks, from the low five bits of its output data bus. Writing 30 therefore gives one request every 30 ms.

Each time the counter arrives at zero it produces an expiry. The next tick reloads the counter, so expiries repeat at the programmed period without further writes. An expiry raises the interrupt request only while a separate enable latch is set. The request then stays high until the controller acknowledges it. Two strobes set and clear the enable latch, and the clear strobe also drops any pending request. Writing zero halts the counter.

Top module: `mint_timer`

## Requirements
- R1: While reset is low, and for the two clock cycles after it rises (reset is released through a two-stage synchronizer), `count_o` is 0 and `irq_o` is 0. Reset also clears the reload value and the enable latch, and restarts both divide stages from zero.
- R2: The tick fires once every DIV_A*DIV_B clock cycles. A running counter therefore changes value exactly once per DIV_A*DIV_B cycles.
- R3: A cycle with `load_i` high writes `data_i` into both the counter and the reload value. `count_o` shows the new value in the next cycle.
- R4: On a tick, a nonzero count decrements by one. On a tick, a count of zero with a nonzero reload value N becomes N-1. A reload value N therefore gives an expiry every N ticks.
- R5: `irq_o` rises only in the cycle after an expiry that happens while the enable latch is set. An expiry with the latch clear leaves `irq_o` low.
- R6: Once set, `irq_o` stays high until an `ack_i` or `en_clr_i` strobe.
- R7: With a reload value of zero, the counter holds at 0 and no expiry or request occurs.
- R8: When a load and a tick fall in the same cycle, the load wins. The counter takes `data_i`, and that tick neither decrements nor expires it.
- R9: `en_set_i` sets the enable latch and `en_clr_i` clears it, and clear wins when both are high. `en_clr_i` also forces `irq_o` low in the next cycle, even over a simultaneous expiry.
- R10: When an expiry with the latch set and an `ack_i` fall in the same cycle, `irq_o` is high in the next cycle: the new request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock feeding the prescaler |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Write strobe for the period value |
| data_i | input | CNT_W | Period value (low bits of controller output bus) |
| en_set_i | input | 1 | Sets the enable latch |
| en_clr_i | input | 1 | Clears the enable latch and any pending request |
| ack_i | input | 1 | Acknowledges and drops the request |
| irq_o | output | 1 | Interrupt request to the controller |
| count_o | output | CNT_W | Present counter value |

## Verification
Two pairs of events can land in the same clock edge. A period write can coincide with the divided tick, and an acknowledge can coincide with a fresh expiry. The bench follows the prescaler phase in its own model and drives the strobe on the edge just before the tick. It then expects the written value to appear undecremented and, in the second case, the request to remain high. Random strobes over many periods also make these and the enable set/clear collisions happen by chance. Each one is judged against the model's prediction on every cycle.

// File: rtl/mint_pkg.sv
package mint_pkg;
  localparam int unsigned MINT_DIV_A = 16;
  localparam int unsigned MINT_DIV_B = 512;
  localparam int unsigned MINT_CNT_W = 5;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_WRAP = 2'd3
  } mint_act_e;
endpackage

// File: rtl/mint_div.sv
module mint_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign pulse_o = en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = pulse_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mint_down.sv
module mint_down
  import mint_pkg::*;
#(
  parameter int unsigned CW = MINT_CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] data_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] reload_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, rld_q;
  mint_act_e     act;

  always_comb begin
    if (load_i)                    act = ACT_LOAD;
    else if (tick_i && rld_q != 0) act = (cnt_q == 0) ? ACT_WRAP : ACT_DEC;
    else                           act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: cnt_d = data_i;
      ACT_DEC:  cnt_d = cnt_q - 1'b1;
      ACT_WRAP: cnt_d = rld_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign expire_o = ((act == ACT_DEC)  && (cnt_q == ONE)) ||
                    ((act == ACT_WRAP) && (rld_q == ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (act != ACT_HOLD) cnt_q <= cnt_d;
      if (load_i)          rld_q <= data_i;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
endmodule

// File: rtl/mint_irq.sv
module mint_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic ack_i,
  output logic en_o,
  output logic irq_o
);
  logic en_q, en_d, irq_q, irq_d;

  always_comb begin
    if (en_clr_i)      en_d = 1'b0;
    else if (en_set_i) en_d = 1'b1;
    else               en_d = en_q;
  end

  always_comb begin
    if (en_clr_i)              irq_d = 1'b0;
    else if (expire_i && en_q) irq_d = 1'b1;
    else if (ack_i)            irq_d = 1'b0;
    else                       irq_d = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mint_timer.sv
module mint_timer
  import mint_pkg::*;
#(
  parameter int unsigned DIV_A = MINT_DIV_A,
  parameter int unsigned DIV_B = MINT_DIV_B,
  parameter int unsigned CNT_W = MINT_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned NSTG = 2;

  logic rs_meta_q, rst_sync;
  logic [NSTG:0] stg;
  logic tick, expire, en_q;
  logic [CNT_W-1:0] rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_meta_q <= 1'b0;
      rst_sync  <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rst_sync  <= rs_meta_q;
    end
  end

  assign stg[0] = 1'b1;
  for (genvar g = 0; g < NSTG; g++) begin : g_pre
    mint_div #(.DIV((g == 0) ? DIV_A : DIV_B)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_sync),
      .en_i   (stg[g]),
      .pulse_o(stg[g+1])
    );
  end
  assign tick = stg[NSTG];

  mint_down #(.CW(CNT_W)) u_down (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .tick_i  (tick),
    .load_i  (load_i),
    .data_i  (data_i),
    .count_o (count_o),
    .reload_o(rld_q),
    .expire_o(expire)
  );

  mint_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .expire_i(expire),
    .en_set_i(en_set_i),
    .en_clr_i(en_clr_i),
    .ack_i   (ack_i),
    .en_o    (en_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/mint_timer_chk.sv
module mint_timer_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          tick,
  input logic          load_i,
  input logic [CW-1:0] data_i,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] rld,
  input logic          en,
  input logic          en_clr_i,
  input logic          ack_i,
  input logic          irq_o
);
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_i)
    tick |=> !tick); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_i)
    load_i |=> (count_o == $past(data_i))); // R8
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_i)
    (tick && !load_i && count_o != 0) |=> (count_o == $past(count_o) - 1'b1)); // R4
  AST_ZERO_STOP: assert property (@(posedge clk_i) disable iff (!rst_i)
    (rld == 0 && !load_i) |=> (count_o == 0 && !$rose(irq_o))); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_i)
    $rose(irq_o) |-> (count_o == 0 && $past(en))); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_i)
    (irq_o && !ack_i && !en_clr_i) |=> irq_o); // R6
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_i)
    en_clr_i |=> (!irq_o && !en)); // R9
endmodule

bind mint_timer mint_timer_chk #(.CW(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_sync),
  .tick    (tick),
  .load_i  (load_i),
  .data_i  (data_i),
  .count_o (count_o),
  .rld     (rld_q),
  .en      (en_q),
  .en_clr_i(en_clr_i),
  .ack_i   (ack_i),
  .irq_o   (irq_o)
);

// File: tb/mint_timer_tb.sv
module mint_timer_tb;
  localparam int D1 = 4;
  localparam int D2 = 8;
  localparam int TOT = D1 * D2;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic load, en_set, en_clr, ack;
  logic [CW-1:0] data;
  logic irq;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  mint_timer #(.DIV_A(D1), .DIV_B(D2), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data),
    .en_set_i(en_set), .en_clr_i(en_clr), .ack_i(ack),
    .irq_o(irq), .count_o(count)
  );

  int total = 0, bad = 0;
  bit started = 0, done = 0;
  string cur = "R1";
  int cyc_n = 0;

  // reference model
  logic m_rs1, m_rs2, m_en, m_irq;
  int m_c1, m_c2;
  logic [CW-1:0] m_cnt, m_rld;

  function automatic logic [CW-1:0] f_next(logic [CW-1:0] c, logic [CW-1:0] r,
                                           logic tk, logic ld, logic [CW-1:0] d);
    if (ld) return d;
    if (!tk || r == 0) return c;
    return (c == 0) ? r - 1'b1 : c - 1'b1;
  endfunction

  function automatic logic f_exp(logic [CW-1:0] c, logic [CW-1:0] r, logic tk, logic ld);
    return tk && !ld && r != 0 && ((c == 1) || (c == 0 && r == 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 <= 0; m_rs2 <= 0; m_en <= 0; m_irq <= 0;
      m_c1 <= 0; m_c2 <= 0; m_cnt <= '0; m_rld <= '0;
    end else begin
      logic tk, ex;
      m_rs1 <= 1'b1;
      m_rs2 <= m_rs1;
      if (m_rs2) begin
        tk = (m_c1 == D1 - 1) && (m_c2 == D2 - 1);
        ex = f_exp(m_cnt, m_rld, tk, load);
        m_c1 <= (m_c1 == D1 - 1) ? 0 : m_c1 + 1;
        if (m_c1 == D1 - 1) m_c2 <= (m_c2 == D2 - 1) ? 0 : m_c2 + 1;
        m_cnt <= f_next(m_cnt, m_rld, tk, load, data);
        if (load) m_rld <= data;
        m_en  <= en_clr ? 1'b0 : (en_set ? 1'b1 : m_en);
        m_irq <= en_clr ? 1'b0 : ((ex && m_en) ? 1'b1 : (ack ? 1'b0 : m_irq));
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    if (started) begin
      chk(cur, "model count", count, m_cnt);
      chk(cur, "model irq", irq, m_irq);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic strobe(logic ld, logic [CW-1:0] d, logic s, logic c, logic a);
    load = ld; data = d; en_set = s; en_clr = c; ack = a;
    cyc();
    load = 0; en_set = 0; en_clr = 0; ack = 0;
  endtask

  task automatic to_pre_tick();
    while (!((m_c1 == D1 - 1) && (m_c2 == D2 - 1))) cyc();
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      if (irq) begin at = cyc_n; break; end
      cyc();
    end
  endtask

  initial begin
    int t0, t1, prev;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; load = 0; en_set = 0; en_clr = 0; ack = 0; data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", count, 0);
    chk("R1", "irq in reset", irq, 0);
    rst_n = 1;
    started = 1;
    cyc(); cyc();
    chk("R1", "count after release", count, 0);
    chk("R1", "irq after release", irq, 0);

    cur = "R3";
    strobe(1, 5'd19, 0, 0, 0);
    chk("R3", "loaded value", count, 19);

    cur = "R2";
    prev = count; t0 = -1; t1 = -1;
    for (int i = 0; i < 200 && t1 < 0; i++) begin
      cyc();
      if (count != prev) begin
        if (t0 < 0) t0 = cyc_n; else t1 = cyc_n;
        prev = count;
      end
    end
    chk("R2", "cycles per tick", t1 - t0, TOT);

    cur = "R5";
    strobe(1, 5'd2, 0, 0, 0);
    repeat (5 * TOT) cyc();
    chk("R5", "no irq while disabled", irq, 0);
    strobe(0, '0, 1, 0, 0);
    wait_irq(t0);
    chk("R5", "irq after enabled expiry", (t0 >= 0) ? 1 : 0, 1);
    chk("R5", "count at irq", count, 0);

    cur = "R6";
    repeat (40) cyc();
    chk("R6", "irq held", irq, 1);
    strobe(0, '0, 0, 0, 1);
    chk("R6", "irq after ack", irq, 0);

    cur = "R4";
    strobe(1, 5'd3, 0, 0, 0);
    wait_irq(t0);
    strobe(0, '0, 0, 0, 1);
    wait_irq(t1);
    chk("R4", "irq period in cycles", t1 - t0, 3 * TOT);
    strobe(0, '0, 0, 0, 1);

    cur = "R8";
    to_pre_tick();
    strobe(1, 5'd7, 0, 0, 0);
    chk("R8", "load beats tick", count, 7);
    cyc();
    chk("R8", "no decrement after", count, 7);

    cur = "R7";
    strobe(1, 5'd0, 0, 0, 1);
    repeat (4 * TOT) cyc();
    chk("R7", "count held at zero", count, 0);
    chk("R7", "no irq with zero period", irq, 0);

    cur = "R10";
    strobe(1, 5'd1, 0, 0, 0);
    to_pre_tick();
    strobe(0, '0, 0, 0, 1);
    chk("R10", "expiry kept over ack", irq, 1);

    cur = "R9";
    strobe(0, '0, 1, 1, 0);
    chk("R9", "clear wins irq", irq, 0);
    repeat (3 * TOT) cyc();
    chk("R9", "latch cleared no irq", irq, 0);
    strobe(0, '0, 1, 0, 0);
    repeat (TOT + 2) cyc();
    chk("R9", "latch set irq again", irq, 1);

    cur = "R4";
    for (int i = 0; i < 8000; i++) begin
      load   = ($urandom_range(0, 149) == 0);
      data   = ($urandom_range(0, 3) == 0) ? CW'($urandom_range(0, 1)) : CW'($urandom_range(0, 6));
      en_set = ($urandom_range(0, 39) == 0);
      en_clr = ($urandom_range(0, 299) == 0);
      ack    = ($urandom_range(0, 19) == 0);
      cyc();
    end
    load = 0; en_set = 0; en_clr = 0; ack = 0;
    cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule